// File: doc/BRIEF.md
# Multi-Mode 24-Bit Timer Core

This block is the counting engine of a general-purpose timer. A 24-bit up-counter advances on a prescaled tick. The tick comes from one of three sources: every system clock cycle, the system clock divided by a selectable power of two, or an external one-cycle enable. The operating mode sets what happens when the counter reaches its compare values:

- **Interval mode:** the counter stops at a limit, or restarts from zero.
- **Pulse mode:** a square-wave flip-flop output toggles at two thresholds.
- **Watchdog mode:** the counter keeps running even while its enable is low, unless that behaviour is explicitly turned off.

A surrounding register block supplies the control fields and compare values as plain inputs. It receives back the counter value and single-cycle set pulses for four status flags. It also receives an interrupt request pulse and the flip-flop level. All of these outputs are registered. A status pulse and the counter value it belongs to appear in the same cycle. A synchronous clear input lets the register interface zero the counter. The reset input is asynchronous and active-low, and the block releases it internally through a two-stage synchronizer.

Top module: `tmr24_core`

## Requirements
- R1: After reset, `count` is 0, all flag pulses and `irq` are low, and `ff_out` holds the value of `ff_init` sampled while the internal reset is released.
- R2: With `src_ext`=0 and `div_en`=0, every cycle is a tick. With `src_ext`=1, a cycle is a tick only when `ext_tick` is high.
- R3: With `src_ext`=0 and `div_en`=1, a tick occurs once every 2^(1+`div_sel`) cycles. Any change of `src_ext`, `div_en` or `div_sel` suppresses the tick in the cycle of the change and restarts the divider, so the first divided tick comes a full period later.
- R4: In mode 0 (interval), the counter advances on a tick only while `run_en`=1 and `count` differs from `cmp_a`. When the incremented value equals `cmp_a`, `flag_iv` pulses and `irq` pulses if `ie_iv`=1. The counter then becomes 0 if `zero_clr`=1, or `cmp_a` otherwise.
- R5: In mode 0, a counter sitting at `cmp_a` stays there and produces no further `flag_iv` or `irq` pulses.
- R6: In mode 1 (pulse), the counter advances on a tick while `run_en`=1. When the incremented value equals `cmp_a`, `ff_out` toggles, `flag_a` pulses, `irq` pulses if `ie_a`=1, and the counter takes the incremented value.
- R7: In mode 1, when the incremented value equals `cmp_b` but not `cmp_a`, `ff_out` toggles, `flag_b` pulses, `irq` pulses if `ie_b`=1, and the counter becomes 0. When `cmp_a` equals `cmp_b`, the A action wins and the counter does not clear.
- R8: In mode 2 (watchdog), the counter advances on every tick unless `run_en`=0 and `wd_dis`=1 at the same time.
- R9: In mode 2, when the incremented value equals `cmp_a`, `flag_wd` pulses, `irq` pulses if `ie_wd`=1, and the counter becomes 0.
- R10: In mode 3 the counter never changes except by `cnt_clear`, whatever `run_en` is.
- R11: `cnt_clear`=1 sets the counter to 0 at the next edge, takes precedence over any tick, and produces no flag or `irq` pulse in that cycle.
- R12: All outputs are registered. A flag pulse and `irq` last one cycle and appear in the same cycle as the counter value that caused them. `irq` is only ever high together with a flag pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 interval, 1 pulse, 2 watchdog, 3 halted |
| run_en | input | 1 | Count enable |
| src_ext | input | 1 | 1 selects the external tick, 0 the system clock |
| div_en | input | 1 | Enables the power-of-two divider on the system clock |
| div_sel | input | 3 | Divider exponent: period is 2^(1+div_sel) cycles |
| ext_tick | input | 1 | External one-cycle tick enable |
| zero_clr | input | 1 | Interval mode: clear to zero at the compare point |
| wd_dis | input | 1 | Watchdog stops when this is 1 and run_en is 0 |
| ie_iv | input | 1 | Interrupt enable for the interval event |
| ie_a | input | 1 | Interrupt enable for the pulse-mode A event |
| ie_b | input | 1 | Interrupt enable for the pulse-mode B event |
| ie_wd | input | 1 | Interrupt enable for the watchdog event |
| ff_init | input | 1 | Value loaded into the flip-flop on reset |
| cmp_a | input | 24 | First compare value |
| cmp_b | input | 24 | Second compare value (pulse mode) |
| cnt_clear | input | 1 | Synchronous counter clear |
| count | output | 24 | Counter value |
| flag_iv | output | 1 | Interval flag set pulse |
| flag_a | output | 1 | Pulse-mode A flag set pulse |
| flag_b | output | 1 | Pulse-mode B flag set pulse |
| flag_wd | output | 1 | Watchdog flag set pulse |
| irq | output | 1 | Interrupt request pulse |
| ff_out | output | 1 | Pulse generator flip-flop |

## Verification
The interval mode is run twice, once with zero-clear and once without. These runs separate the wrap-to-zero path from the hold path, and the held state is then watched for repeated interrupts. The pulse mode is run three times: with distinct A and B thresholds, once with each interrupt enable alone, and once with equal thresholds. Together these expose the toggle pairing, the per-event interrupt gating and the A-over-B priority. The watchdog mode is stepped through every combination of enable and disable, and the tick source is walked through the undivided, divided-by-4, divided-by-2 and external cases. The switch-over cycles show the restart of the divider and the suppressed tick.

// File: rtl/tmr24_pkg.sv
package tmr24_pkg;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_PULSE    = 2'd1,
    MODE_WATCHDOG = 2'd2,
    MODE_HALT     = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic iv;
    logic a;
    logic b;
    logic wd;
  } tmr_evt_t;

endpackage

// File: rtl/tmr24_prescale.sv
module tmr24_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_ext,
  input  logic             div_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             ext_tick,
  output logic             tick
);

  localparam int PRE_W = 1 << DIV_W;
  localparam int CFG_W = DIV_W + 2;

  logic [CFG_W-1:0] cfg_d, cfg_q;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W:0]   span, span_m1;
  logic             changed, pre_en;

  always_comb begin
    cfg_d   = {src_ext, div_en, div_sel};
    changed = (cfg_d != cfg_q);
    span    = (PRE_W+1)'(1) << ((DIV_W+1)'(div_sel) + (DIV_W+1)'(1));
    span_m1 = span - (PRE_W+1)'(1);
    tick    = 1'b0;
    pre_d   = pre_q;
    pre_en  = 1'b0;
    if (changed) begin
      pre_d  = '0;
      pre_en = 1'b1;
    end else if (src_ext) begin
      tick = ext_tick;
    end else if (!div_en) begin
      tick = 1'b1;
    end else begin
      tick   = (pre_q == span_m1[PRE_W-1:0]);
      pre_d  = tick ? '0 : pre_q + 1'b1;
      pre_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (changed) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end

  // R3: divided ticks are never back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_ext && div_en && tick) |=> !tick);

endmodule

// File: rtl/tmr24_step.sv
module tmr24_step
  import tmr24_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  tmr_mode_e        mode,
  input  logic             run_en,
  input  logic             wd_dis,
  input  logic             zero_clr,
  input  logic             tick,
  input  logic             cnt_clear,
  input  logic             ie_iv,
  input  logic             ie_a,
  input  logic             ie_b,
  input  logic             ie_wd,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             cnt_we,
  output tmr_evt_t         evt,
  output logic             irq_d,
  output logic             ff_flip
);

  logic [CNT_W-1:0] inc;
  logic             advance;

  always_comb begin
    inc = count + 1'b1;
    case (mode)
      MODE_INTERVAL: advance = run_en && (count != cmp_a);
      MODE_PULSE:    advance = run_en;
      MODE_WATCHDOG: advance = run_en || !wd_dis;
      default:       advance = 1'b0;
    endcase
  end

  always_comb begin
    cnt_nxt = inc;
    cnt_we  = 1'b0;
    evt     = '0;
    irq_d   = 1'b0;
    ff_flip = 1'b0;
    if (cnt_clear) begin
      cnt_we  = 1'b1;
      cnt_nxt = '0;
    end else if (tick && advance) begin
      cnt_we = 1'b1;
      case (mode)
        MODE_INTERVAL: begin
          if (inc == cmp_a) begin
            evt.iv = 1'b1;
            irq_d  = ie_iv;
            if (zero_clr) cnt_nxt = '0;
          end
        end
        MODE_PULSE: begin
          if (inc == cmp_a) begin
            ff_flip = 1'b1;
            evt.a   = 1'b1;
            irq_d   = ie_a;
          end else if (inc == cmp_b) begin
            ff_flip = 1'b1;
            evt.b   = 1'b1;
            irq_d   = ie_b;
            cnt_nxt = '0;
          end
        end
        MODE_WATCHDOG: begin
          if (inc == cmp_a) begin
            evt.wd  = 1'b1;
            irq_d   = ie_wd;
            cnt_nxt = '0;
          end
        end
        default: cnt_we = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/tmr24_outreg.sv
module tmr24_outreg
  import tmr24_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rst_sync_n,
  input  tmr_evt_t evt_d,
  input  logic     irq_d,
  input  logic     ff_flip,
  input  logic     ff_init,
  output tmr_evt_t evt_q,
  output logic     irq_q,
  output logic     ff_q
);

  logic ff_d;

  always_comb begin
    ff_d = ff_q ^ ff_flip;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      evt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      irq_q <= irq_d;
    end
  end

  // loads ff_init while the synchronized reset is still low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
    end else if (!rst_sync_n) begin
      ff_q <= ff_init;
    end else if (ff_flip) begin
      ff_q <= ff_d;
    end
  end

  // R12: interrupt only together with a flag pulse
  a_r12_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_q |-> (evt_q != '0));

endmodule

// File: rtl/tmr24_core.sv
module tmr24_core
  import tmr24_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             run_en,
  input  logic             src_ext,
  input  logic             div_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             ext_tick,
  input  logic             zero_clr,
  input  logic             wd_dis,
  input  logic             ie_iv,
  input  logic             ie_a,
  input  logic             ie_b,
  input  logic             ie_wd,
  input  logic             ff_init,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             cnt_clear,
  output logic [CNT_W-1:0] count,
  output logic             flag_iv,
  output logic             flag_a,
  output logic             flag_b,
  output logic             flag_wd,
  output logic             irq,
  output logic             ff_out
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q;
  logic                   tick;
  logic [CNT_W-1:0]       count_q, cnt_nxt;
  logic                   cnt_we, irq_d, ff_flip;
  tmr_evt_t               evt_d, evt_q;
  tmr_mode_e              mode_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  always_comb begin
    rst_q  = rst_pipe[SYNC_STAGES-1];
    mode_e = tmr_mode_e'(mode);
  end

  tmr24_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_q),
    .src_ext  (src_ext),
    .div_en   (div_en),
    .div_sel  (div_sel),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  tmr24_step #(.CNT_W(CNT_W)) u_step (
    .count     (count_q),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .mode      (mode_e),
    .run_en    (run_en),
    .wd_dis    (wd_dis),
    .zero_clr  (zero_clr),
    .tick      (tick),
    .cnt_clear (cnt_clear),
    .ie_iv     (ie_iv),
    .ie_a      (ie_a),
    .ie_b      (ie_b),
    .ie_wd     (ie_wd),
    .cnt_nxt   (cnt_nxt),
    .cnt_we    (cnt_we),
    .evt       (evt_d),
    .irq_d     (irq_d),
    .ff_flip   (ff_flip)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      count_q <= '0;
    end else if (cnt_we) begin
      count_q <= cnt_nxt;
    end
  end

  tmr24_outreg u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q),
    .evt_d      (evt_d),
    .irq_d      (irq_d),
    .ff_flip    (ff_flip),
    .ff_init    (ff_init),
    .evt_q      (evt_q),
    .irq_q      (irq),
    .ff_q       (ff_out)
  );

  always_comb begin
    count   = count_q;
    flag_iv = evt_q.iv;
    flag_a  = evt_q.a;
    flag_b  = evt_q.b;
    flag_wd = evt_q.wd;
  end

  // R10: halted mode leaves the counter alone
  a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_q)
    (mode == 2'd3 && !cnt_clear) |=> $stable(count_q));

  // R11: clear zeroes the counter with no event
  a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_clear |=> (count_q == '0 && evt_q == '0 && !irq));

  // R5: holding at compare A is quiet
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    (mode == 2'd0 && count_q == cmp_a && !cnt_clear) |=> ($stable(count_q) && !flag_iv && !irq));

  // R8: watchdog stops only with run_en low and wd_dis high
  a_r8_wd_stopped: assert property (@(posedge clk) disable iff (!rst_q)
    (mode == 2'd2 && !run_en && wd_dis && !cnt_clear) |=> $stable(count_q));

  // R7: the B event leaves the counter at zero
  a_r7_b_clears: assert property (@(posedge clk) disable iff (!rst_q)
    flag_b |-> (count_q == '0));

  // R9: watchdog expiry leaves the counter at zero
  a_r9_wd_clears: assert property (@(posedge clk) disable iff (!rst_q)
    flag_wd |-> (count_q == '0));

  // R12: at most one flag pulse per cycle
  a_r12_one_flag: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({flag_iv, flag_a, flag_b, flag_wd}));

endmodule

// File: tb/tmr24_core_test.sv
module tmr24_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct {
    int         cnt;
    logic [4:0] ev;   // {iv, a, b, wd, irq}
    int         ff;   // -1: not checked
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        run_en, src_ext, div_en, ext_tick, zero_clr, wd_dis;
  logic        ie_iv, ie_a, ie_b, ie_wd, ff_init, cnt_clear;
  logic [2:0]  div_sel;
  logic [23:0] cmp_a, cmp_b;
  logic [23:0] count;
  logic        flag_iv, flag_a, flag_b, flag_wd, irq, ff_out;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr24_core uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .run_en(run_en), .src_ext(src_ext),
    .div_en(div_en), .div_sel(div_sel), .ext_tick(ext_tick), .zero_clr(zero_clr),
    .wd_dis(wd_dis), .ie_iv(ie_iv), .ie_a(ie_a), .ie_b(ie_b), .ie_wd(ie_wd),
    .ff_init(ff_init), .cmp_a(cmp_a), .cmp_b(cmp_b), .cnt_clear(cnt_clear),
    .count(count), .flag_iv(flag_iv), .flag_a(flag_a), .flag_b(flag_b),
    .flag_wd(flag_wd), .irq(irq), .ff_out(ff_out)
  );

  localparam logic [4:0] EV_NONE = 5'b00000;
  localparam logic [4:0] EV_IV   = 5'b10000;
  localparam logic [4:0] EV_A    = 5'b01000;
  localparam logic [4:0] EV_B    = 5'b00100;
  localparam logic [4:0] EV_WD   = 5'b00010;
  localparam logic [4:0] EV_IRQ  = 5'b00001;

  // driver: push what the outputs must show after the coming edge
  task automatic cyc(input int cnt, input logic [4:0] ev, input int ff, input string req);
    exp_t e;
    e.cnt = cnt; e.ev = ev; e.ff = ff; e.req = req;
    sb_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: compare one item per edge, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        logic [4:0] act;
        e = sb_q.pop_front();
        act = {flag_iv, flag_a, flag_b, flag_wd, irq};
        checks++;
        if (count !== 24'(e.cnt) || act !== e.ev || (e.ff >= 0 && ff_out !== 1'(e.ff))) begin
          errors++;
          $display("FAIL %s: count=%0d ev=%b ff=%b, expected count=%0d ev=%b ff=%0d",
                   e.req, count, act, ff_out, e.cnt, e.ev, e.ff);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'd3; run_en = 1'b0; src_ext = 1'b0; div_en = 1'b0;
    div_sel = 3'd0; ext_tick = 1'b0; zero_clr = 1'b0; wd_dis = 1'b0;
    ie_iv = 1'b0; ie_a = 1'b0; ie_b = 1'b0; ie_wd = 1'b0; ff_init = 1'b1;
    cmp_a = 24'hFFFFFF; cmp_b = 24'hFFFFFF; cnt_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, flip-flop took ff_init
    cyc(0, EV_NONE, 1, "R1");
    cyc(0, EV_NONE, 1, "R1");

    // R2 / R4: undivided ticks, interval with zero-clear and interrupt
    mode = 2'd0; cmp_a = 24'd4; zero_clr = 1'b1; ie_iv = 1'b1; run_en = 1'b1;
    cyc(1, EV_NONE, 1, "R2");
    cyc(2, EV_NONE, 1, "R2");
    cyc(3, EV_NONE, 1, "R4");
    cyc(0, EV_IV | EV_IRQ, 1, "R4 R12");
    cyc(1, EV_NONE, 1, "R12");
    run_en = 1'b0;
    cyc(1, EV_NONE, 1, "R4");
    cnt_clear = 1'b1;
    cyc(0, EV_NONE, 1, "R11");
    cnt_clear = 1'b0;

    // R5: interval hold without zero-clear
    zero_clr = 1'b0; cmp_a = 24'd3; run_en = 1'b1;
    cyc(1, EV_NONE, 1, "R4");
    cyc(2, EV_NONE, 1, "R4");
    cyc(3, EV_IV | EV_IRQ, 1, "R4 R12");
    cyc(3, EV_NONE, 1, "R5");
    cyc(3, EV_NONE, 1, "R5");
    cnt_clear = 1'b1;
    cyc(0, EV_NONE, 1, "R11");
    cyc(0, EV_NONE, 1, "R11");
    cnt_clear = 1'b0; ie_iv = 1'b0; cmp_a = 24'd2;
    cyc(1, EV_NONE, 1, "R4");
    cyc(2, EV_IV, 1, "R4");
    run_en = 1'b0; cnt_clear = 1'b1;
    cyc(0, EV_NONE, 1, "R11");
    cnt_clear = 1'b0;

    // R6 / R7: pulse mode, A interrupt only
    mode = 2'd1; cmp_a = 24'd2; cmp_b = 24'd4; ie_a = 1'b1; run_en = 1'b1;
    cyc(1, EV_NONE, 1, "R6");
    cyc(2, EV_A | EV_IRQ, 0, "R6");
    cyc(3, EV_NONE, 0, "R6");
    cyc(0, EV_B, 1, "R7");
    cyc(1, EV_NONE, 1, "R7");
    cyc(2, EV_A | EV_IRQ, 0, "R6");
    run_en = 1'b0;
    cyc(2, EV_NONE, 0, "R6");
    // B interrupt only
    ie_a = 1'b0; ie_b = 1'b1; run_en = 1'b1;
    cyc(3, EV_NONE, 0, "R7");
    cyc(0, EV_B | EV_IRQ, 1, "R7");
    cyc(1, EV_NONE, 1, "R7");
    cyc(2, EV_A, 0, "R6");
    run_en = 1'b0; cnt_clear = 1'b1;
    cyc(0, EV_NONE, 0, "R11");
    cnt_clear = 1'b0;
    // equal thresholds: A wins, no clear
    cmp_b = 24'd2; run_en = 1'b1;
    cyc(1, EV_NONE, 0, "R7");
    cyc(2, EV_A, 1, "R7");
    cyc(3, EV_NONE, 1, "R7");
    run_en = 1'b0; cnt_clear = 1'b1; ie_b = 1'b0;
    cyc(0, EV_NONE, 1, "R11");
    cnt_clear = 1'b0;

    // R8 / R9: watchdog
    mode = 2'd2; cmp_a = 24'd3; ie_wd = 1'b1; wd_dis = 1'b0; run_en = 1'b0;
    cyc(1, EV_NONE, -1, "R8");
    cyc(2, EV_NONE, -1, "R8");
    cyc(0, EV_WD | EV_IRQ, -1, "R9");
    cyc(1, EV_NONE, -1, "R8");
    wd_dis = 1'b1;
    cyc(1, EV_NONE, -1, "R8");
    cyc(1, EV_NONE, -1, "R8");
    run_en = 1'b1;
    cyc(2, EV_NONE, -1, "R8");
    cyc(0, EV_WD | EV_IRQ, -1, "R9");
    ie_wd = 1'b0;
    cyc(1, EV_NONE, -1, "R9");
    cyc(2, EV_NONE, -1, "R9");
    cyc(0, EV_WD, -1, "R9");
    cyc(1, EV_NONE, -1, "R9");

    // R10: halted mode with enable on
    mode = 2'd3; wd_dis = 1'b0;
    cyc(1, EV_NONE, -1, "R10");
    cyc(1, EV_NONE, -1, "R10");
    cyc(1, EV_NONE, -1, "R10");
    cnt_clear = 1'b1;
    cyc(0, EV_NONE, -1, "R11");
    cnt_clear = 1'b0;

    // R3: divide by 4, then by 2, restarting at each change
    mode = 2'd0; cmp_a = 24'hFFFFFF; run_en = 1'b1; div_en = 1'b1; div_sel = 3'd1;
    cyc(0, EV_NONE, -1, "R3");
    cyc(0, EV_NONE, -1, "R3");
    cyc(0, EV_NONE, -1, "R3");
    cyc(0, EV_NONE, -1, "R3");
    cyc(1, EV_NONE, -1, "R3");
    cyc(1, EV_NONE, -1, "R3");
    cyc(1, EV_NONE, -1, "R3");
    cyc(1, EV_NONE, -1, "R3");
    cyc(2, EV_NONE, -1, "R3");
    div_sel = 3'd0;
    cyc(2, EV_NONE, -1, "R3");
    cyc(2, EV_NONE, -1, "R3");
    cyc(3, EV_NONE, -1, "R3");
    cyc(3, EV_NONE, -1, "R3");
    cyc(4, EV_NONE, -1, "R3");

    // R2: external tick source
    src_ext = 1'b1; div_en = 1'b0;
    cyc(4, EV_NONE, -1, "R2");
    ext_tick = 1'b1;
    cyc(5, EV_NONE, -1, "R2");
    cyc(6, EV_NONE, -1, "R2");
    ext_tick = 1'b0;
    cyc(6, EV_NONE, -1, "R2");
    cyc(6, EV_NONE, -1, "R2");
    ext_tick = 1'b1;
    cyc(7, EV_NONE, -1, "R2");
    ext_tick = 1'b0;
    cyc(7, EV_NONE, -1, "R2");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule